// File: doc/BRIEF.md
# Policy-Enforcing Configuration Register Bank

This block is a small bank of 32-bit configuration words reached through a simple register port. The port carries a word address, write data with per-byte enables, a write strobe and a read strobe. Each field in the bank follows its own access rule. A field can be plain read/write. It can be read/write with hardware self-clear and a lock. It can be write-once, frozen until reset. It can be write-only, where the write acts only as a side effect.

Hardware pulses on `hw_clr` knock individual self-clearing bits back to zero. A hardware clear always beats software, even when software writes a 1 in the same cycle. A single lock bit sits in its own word and can be written only once. When set, it makes the self-clearing field read-only for software until reset, although hardware can still clear its bits. Write-once capture is atomic per word: the first write access to the word freezes the whole word, whichever bytes were enabled. Writes to the trigger word reach the side-effect output as a one-cycle pulse carrying the written data; there is no back-pressure on this output. Read data is registered and appears, with `rd_valid`, one cycle after the read strobe.

Word map (word address): 0 plain, 1 self-clear/lockable, 2 write-once, 3 write-only trigger, 4 lock control; every other address is unmapped.

Top module: `cfg_attr_bank`

## Requirements
- R1: After reset every mapped word reads back zero and the lock is clear.
- R2: Word 0 is plain read/write; a write changes only the bytes whose `be` bit is set (be[k] covers wdata[8k+7:8k]).
- R3: Word 1 bits [SC_W-1:0] are software-writable per byte while unlocked; bits [31:SC_W] always read zero.
- R4: A `hw_clr[i]` pulse clears word 1 bit i, visible on a read issued the following cycle, even if software writes 1 to that bit in the same cycle, and even while locked.
- R5: Once word 4 bit 0 reads 1, software writes to word 1 are ignored; hardware clears still take effect.
- R6: Word 2 is write-once: the first write access after reset stores the enabled bytes (disabled bytes stay zero) and freezes the whole word; later writes are ignored until reset.
- R7: Word 4 is itself write-once: its first write access stores bit 0 (from wdata[0] if be[0] is set, else 0) and freezes it, so a lock can be neither removed nor set later without reset.
- R8: A write to word 3 raises `trig_valid` in the same cycle with `trig_data` equal to wdata with disabled bytes zeroed; word 3 always reads zero.
- R9: Unmapped addresses read zero and writes to them change no mapped word.
- R10: `rd_valid` is high exactly one cycle after `rd_en`, with `rdata` holding the addressed word as it stood before any write in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables for the write |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| hw_clr | input | SC_W | Per-bit hardware clear for word 1 |
| trig_valid | output | 1 | One-cycle side-effect pulse for a word-3 write |
| trig_data | output | 32 | Byte-masked data of the word-3 write |

## Verification
The assertions assume `hw_clr` and the strobes are clean one-bit values sampled on the rising edge. They also assume `addr` is stable through a strobe cycle. Reads may coincide with writes and with clears. Random stimulus drives every input only at the falling edge. It mixes reads, writes and sparse clear pulses over mapped and unmapped addresses. Lock writes are kept rare, so that long unlocked stretches come before the lock freezes word 1. Directed cases cover the same-cycle clear/write race and a write-once access with partial byte enables. They also cover a lock word written with byte 0 disabled, and reset as the only way to re-open write-once words.

// File: rtl/cfg_attr_pkg.sv
package cfg_attr_pkg;
  localparam int CFG_DW = 32;
  localparam int CFG_BE = CFG_DW / 8;

  localparam int A_PLAIN = 0;
  localparam int A_SCLR  = 1;
  localparam int A_ONCE  = 2;
  localparam int A_TRIG  = 3;
  localparam int A_LOCK  = 4;
  localparam int NUM_WORDS = 5;

  function automatic logic [CFG_DW-1:0] be_to_mask(input logic [CFG_BE-1:0] b);
    logic [CFG_DW-1:0] m;
    for (int k = 0; k < CFG_BE; k++) m[k*8 +: 8] = {8{b[k]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg_sc_bits.sv
module cfg_sc_bits #(
  parameter int W        = 16,
  parameter bit LOCKABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  input  logic         lock,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic eff_lock;
  assign eff_lock = LOCKABLE ? lock : 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                            q[i] <= 1'b0;
      else if (clr[i])                       q[i] <= 1'b0;
      else if (we && wmask[i] && !eff_lock)  q[i] <= wdata[i];
    end

    // R4: hardware clear wins over any software write
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !q[i]);
  end

  // R5: locked bits hold unless hardware clears them
  a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_lock && !(|clr)) |=> $stable(q));
endmodule

// File: rtl/cfg_once_word.sv
module cfg_once_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= '0;
      done <= 1'b0;
    end else if (we && !done) begin
      q    <= (q & ~wmask) | (wdata & wmask);
      done <= 1'b1;
    end
  end

  // R6: once captured, the word and its flag stay frozen until reset
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(q) && done));
endmodule

// File: rtl/cfg_attr_bank.sv
module cfg_attr_bank
  import cfg_attr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [CFG_DW-1:0] wdata,
  input  logic [CFG_BE-1:0] be,
  input  logic              rd_en,
  output logic [CFG_DW-1:0] rdata,
  output logic              rd_valid,
  input  logic [SC_W-1:0]   hw_clr,
  output logic              trig_valid,
  output logic [CFG_DW-1:0] trig_data
);
  logic [CFG_DW-1:0] wmask;
  logic hit_plain, hit_sclr, hit_once, hit_trig, hit_lock;
  logic [CFG_DW-1:0] plain_q, once_q;
  logic [SC_W-1:0]   sclr_q;
  logic              once_done;
  logic [0:0]        lock_q;
  logic              lock_done;
  logic [CFG_DW-1:0] rd_word;

  assign wmask     = be_to_mask(be);
  assign hit_plain = wr_en && (addr == ADDR_W'(A_PLAIN));
  assign hit_sclr  = wr_en && (addr == ADDR_W'(A_SCLR));
  assign hit_once  = wr_en && (addr == ADDR_W'(A_ONCE));
  assign hit_trig  = wr_en && (addr == ADDR_W'(A_TRIG));
  assign hit_lock  = wr_en && (addr == ADDR_W'(A_LOCK));

  cfg_sc_bits #(.W(CFG_DW), .LOCKABLE(1'b0)) u_plain (
    .clk(clk), .rst_n(rst_n), .we(hit_plain), .wmask(wmask), .wdata(wdata),
    .lock(1'b0), .clr('0), .q(plain_q));

  cfg_sc_bits #(.W(SC_W), .LOCKABLE(1'b1)) u_sclr (
    .clk(clk), .rst_n(rst_n), .we(hit_sclr), .wmask(wmask[SC_W-1:0]),
    .wdata(wdata[SC_W-1:0]), .lock(lock_q[0]), .clr(hw_clr), .q(sclr_q));

  cfg_once_word #(.W(CFG_DW)) u_once (
    .clk(clk), .rst_n(rst_n), .we(hit_once), .wmask(wmask), .wdata(wdata),
    .q(once_q), .done(once_done));

  cfg_once_word #(.W(1)) u_lock (
    .clk(clk), .rst_n(rst_n), .we(hit_lock), .wmask(wmask[0:0]),
    .wdata(wdata[0:0]), .q(lock_q), .done(lock_done));

  assign trig_valid = hit_trig;
  assign trig_data  = hit_trig ? (wdata & wmask) : '0;

  always_comb begin
    rd_word = '0;
    case (addr)
      ADDR_W'(A_PLAIN): rd_word = plain_q;
      ADDR_W'(A_SCLR):  rd_word = CFG_DW'(sclr_q);
      ADDR_W'(A_ONCE):  rd_word = once_q;
      ADDR_W'(A_LOCK):  rd_word = CFG_DW'(lock_q);
      default:          rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  // R10: one-cycle read latency
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R8: write-only word reads zero
  a_r8_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(A_TRIG)) |=> (rdata == '0));
  // R9: unmapped space reads zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= ADDR_W'(NUM_WORDS)) |=> (rdata == '0));
  // R7: lock word frozen once accessed
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done |=> $stable(lock_q));
endmodule

// File: tb/tb_cfg_attr_bank.sv
module tb_cfg_attr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic wr_en, rd_en;
  logic [31:0] wdata, rdata, trig_data;
  logic [3:0] be;
  logic rd_valid, trig_valid;
  logic [SW-1:0] hw_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_attr_bank #(.ADDR_W(AW), .SC_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .be(be), .rd_en(rd_en), .rdata(rdata), .rd_valid(rd_valid),
    .hw_clr(hw_clr), .trig_valid(trig_valid), .trig_data(trig_data));

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  logic [31:0]   m_plain, m_once;
  logic [SW-1:0] m_sc;
  logic          m_once_done, m_lock, m_lock_done;

  function automatic logic [31:0] bmask(input logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    case (a)
      4'd0: return m_plain;
      4'd1: return {16'h0, m_sc};
      4'd2: return m_once;
      4'd4: return {31'h0, m_lock};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [AW-1:0] a);
    case (a)
      4'd0: return "R2";
      4'd1: return "R3/R4/R5";
      4'd2: return "R6";
      4'd3: return "R8";
      4'd4: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_plain = '0; m_once = '0; m_sc = '0;
    m_once_done = 1'b0; m_lock = 1'b0; m_lock_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; be = '0; hw_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // one cycle: drive at negedge, check pulses, advance, check read
  task automatic step(input logic wr, input logic rd, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [3:0] b,
                      input logic [SW-1:0] clr, input string tag);
    logic [31:0] exp_rd, m;
    exp_rd = model_read(a);
    m = bmask(b);
    wr_en = wr; rd_en = rd; addr = a; wdata = d; be = b; hw_clr = clr;
    #1;
    if (wr && a == 4'd3) begin
      check({tag, " R8 trig_valid"}, {31'h0, trig_valid}, 32'h1);
      check({tag, " R8 trig_data"}, trig_data, d & m);
    end else if (wr || rd) begin
      check({tag, " R8 trig idle"}, {31'h0, trig_valid}, 32'h0);
    end
    @(posedge clk);
    if (wr) begin
      case (a)
        4'd0: m_plain = (m_plain & ~m) | (d & m);
        4'd1: if (!m_lock) m_sc = (m_sc & ~m[SW-1:0]) | (d[SW-1:0] & m[SW-1:0]);
        4'd2: if (!m_once_done) begin m_once = (m_once & ~m) | (d & m); m_once_done = 1'b1; end
        4'd4: if (!m_lock_done) begin m_lock = b[0] ? d[0] : m_lock; m_lock_done = 1'b1; end
        default: ;
      endcase
    end
    m_sc = m_sc & ~clr;
    @(negedge clk);
    wr_en = 0; rd_en = 0; hw_clr = '0;
    if (rd) begin
      check({tag, " R10 rd_valid"}, {31'h0, rd_valid}, 32'h1);
      check(tag, rdata, exp_rd);
    end else begin
      check({tag, " R10 no valid"}, {31'h0, rd_valid}, 32'h0);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] b, input string t);
    step(1'b1, 1'b0, a, d, b, '0, t);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string t);
    step(1'b0, 1'b1, a, '0, '0, '0, t);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1: reset state
    for (int a = 0; a < 8; a++) rd(AW'(a), "R1 reset");
    // R2: byte enables on plain word
    wr(4'd0, 32'hA1B2_C3D4, 4'b0101, "R2");
    rd(4'd0, "R2 partial");
    // R3: self-clear word writable, upper bits zero
    wr(4'd1, 32'hFFFF_F0F0, 4'b1111, "R3");
    rd(4'd1, "R3 upper zero");
    // R4: clear beats simultaneous write of 1
    step(1'b1, 1'b0, 4'd1, 32'h0000_000F, 4'b0001, 16'h0005, "R4 race");
    rd(4'd1, "R4 after race");
    // R6: partial byte first write freezes word
    wr(4'd2, 32'h1122_3344, 4'b0001, "R6 first");
    wr(4'd2, 32'hFFFF_FFFF, 4'b1111, "R6 second");
    rd(4'd2, "R6 frozen");
    // R8: trigger and read zero
    wr(4'd3, 32'hDEAD_BEEF, 4'b1010, "R8");
    rd(4'd3, "R8 read zero");
    // R9: unmapped write then read
    wr(4'd9, 32'hFFFF_FFFF, 4'b1111, "R9");
    rd(4'd9, "R9 unmapped");
    rd(4'd0, "R9 plain untouched");
    // R10: read and write same cycle returns old value
    step(1'b1, 1'b1, 4'd0, 32'h5555_5555, 4'b1111, '0, "R10 rd+wr");
    rd(4'd0, "R10 new value");
    // R5: lock then writes ignored, clears still work
    wr(4'd1, 32'h0000_00FF, 4'b0011, "R5 prep");
    wr(4'd4, 32'h0000_0001, 4'b0001, "R5 lock");
    rd(4'd4, "R7 lock set");
    wr(4'd1, 32'h0000_FF00, 4'b0011, "R5 locked write");
    rd(4'd1, "R5 ignored");
    step(1'b0, 1'b0, 4'd0, '0, '0, 16'h0003, "R5 clear while locked");
    rd(4'd1, "R5 clear applied");
    wr(4'd4, 32'h0, 4'b0001, "R7 unlock try");
    rd(4'd4, "R7 still locked");
    // R6/R7: reset re-opens; lock word accessed with be[0]=0
    do_reset();
    rd(4'd2, "R1 once cleared");
    wr(4'd2, 32'h0BAD_F00D, 4'b1111, "R6 after reset");
    rd(4'd2, "R6 recaptured");
    wr(4'd4, 32'h1, 4'b0000, "R7 empty access");
    wr(4'd4, 32'h1, 4'b0001, "R7 late lock");
    rd(4'd4, "R7 stays zero");
    wr(4'd1, 32'h0000_1234, 4'b0011, "R5 unlocked");
    rd(4'd1, "R5 still writable");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic w, r;
      logic [SW-1:0] c;
      int pick;
      pick = $urandom_range(0, 99);
      a = AW'($urandom_range(0, 7));
      if (a == 4'd4 && $urandom_range(0, 19) != 0) a = 4'd1;
      w = pick < 50;
      r = pick >= 30;
      c = ($urandom_range(0, 3) == 0) ? SW'($urandom) & SW'($urandom) : '0;
      if (n == 1500) do_reset();
      step(w, r, a, $urandom, 4'($urandom), c, req_of(a));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule